// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit forms memory addresses and immediate operands for a 32-bit RISC core with 16-bit instructions. Each cycle the decoder may present a request made of an addressing-mode code, an operand size, the Rn and R0 register values, the global base register, the current PC (the instruction address plus 4) and an 8-bit displacement or immediate field. One clock later the unit presents the effective address, the extended immediate, a write-back value and enable for the auto-modify modes, and a misalignment flag. All additions wrap modulo 2^32.

Results leave the block from registers. A two-state controller tracks whether the output registers hold a result that is fresh this cycle. In ST_IDLE no result is on offer. The transition IDLE_TO_RESULT happens on a clock edge where a request is present. ST_RESULT stays in place (RESULT_HOLD) while requests keep arriving one per cycle. RESULT_TO_IDLE happens on an edge with no request. Output data registers load only when a request is present, so the last result stays on the data outputs while the unit is idle.

Top module: `ea_gen_unit`

## Requirements
- R1: After reset is released, out_valid is 0 and ea, imm_value, wb_value, wb_en and misalign are all 0.
- R2: A request sampled at a rising edge drives out_valid to 1 with its results after that edge. An edge with req_valid low drives out_valid to 0 and leaves ea, imm_value, wb_value, wb_en and misalign unchanged.
- R3: Mode 0 gives ea = Rn. Mode 4 gives ea = Rn + R0. Mode 6 gives ea = GBR + R0.
- R4: Mode 1 (post-increment) gives ea = Rn and wb_value = Rn + step. The step is 1, 2 or 4 for size codes 0, 1 and 2 (byte, word, longword).
- R5: Mode 2 (pre-decrement) gives ea = Rn - step and wb_value equal to that same ea.
- R6: Mode 3 gives ea = Rn + zero-extended field[3:0] times step. Field bits 7:4 have no effect in this mode.
- R7: Mode 5 gives ea = GBR + zero-extended field[7:0] times step.
- R8: Mode 7 gives ea = PC + zero-extended field times step. For longword size, PC bits 1:0 are cleared before the add.
- R9: Every address and write-back sum wraps modulo 2^32.
- R10: imm_class 0 zero-extends field to 32 bits. imm_class 1 sign-extends it from bit 7. imm_class 3 yields 0.
- R11: imm_class 2 (trap) yields the zero-extended field times 4.
- R12: wb_en is 1 only for modes 1 and 2. When wb_en is 0, wb_value is 0.
- R13: misalign is 1 when a word access has ea[0] set, or a longword access has ea[1:0] nonzero. It is never set for a byte access.
- R14: Size code 3 behaves exactly as longword (code 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing-mode code, 0 to 7 |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 longword |
| imm_class | input | 2 | Immediate class: 0 zero-extend, 1 sign-extend, 2 trap, 3 none |
| rn | input | ADDR_W | Rn register value |
| r0 | input | ADDR_W | R0 register value |
| gbr | input | ADDR_W | Global base register value |
| pc | input | ADDR_W | Instruction address plus 4 |
| field | input | FIELD_W | Displacement or immediate field |
| out_valid | output | 1 | Registered results belong to the previous cycle's request |
| ea | output | ADDR_W | Effective address |
| imm_value | output | ADDR_W | Extended immediate operand |
| wb_en | output | 1 | Rn write-back enable |
| wb_value | output | ADDR_W | New value for Rn |
| misalign | output | 1 | Address not aligned to the operand size |

## Verification
A controller stuck in the wrong state shows at the next edge. out_valid stays high after a cycle with no request, or stays low after a request, so the bench flags it within one cycle. A wrong scale shift, a missing PC mask or a wrong extension rule shows on ea, imm_value or wb_value in the cycle after the offending request. The bench tries every mode against all four size codes, then runs a long run of back-to-back random requests mixed with idle cycles. Wrap-around values and idle-hold behaviour are aimed at on purpose, so that a fault is caught within the one cycle that uses it.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    typedef enum logic [2:0] {
        AM_IND     = 3'd0,
        AM_POSTINC = 3'd1,
        AM_PREDEC  = 3'd2,
        AM_RDISP   = 3'd3,
        AM_RIDX    = 3'd4,
        AM_GDISP   = 3'd5,
        AM_GIDX    = 3'd6,
        AM_PCDISP  = 3'd7
    } amode_t;

    typedef enum logic [1:0] {
        SZ_B  = 2'd0,
        SZ_W  = 2'd1,
        SZ_L  = 2'd2,
        SZ_LX = 2'd3
    } osize_t;

    typedef enum logic [1:0] {
        IX_ZERO = 2'd0,
        IX_SIGN = 2'd1,
        IX_TRAP = 2'd2,
        IX_NONE = 2'd3
    } iclass_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ostate_t;

    function automatic logic [1:0] size_shift(input osize_t s);
        logic [1:0] r;
        unique case (s)
            SZ_B:    r = 2'd0;
            SZ_W:    r = 2'd1;
            SZ_L:    r = 2'd2;
            SZ_LX:   r = 2'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ea_scaler.sv
module ea_scaler #(
    parameter int IN_W  = 4,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  disp,
    input  logic [1:0]       shamt,
    output logic [OUT_W-1:0] scaled
);
    localparam int PAD_W = OUT_W - IN_W;

    logic [OUT_W-1:0] widened;

    assign widened = {{PAD_W{1'b0}}, disp};

    always_comb begin
        unique case (shamt)
            2'd0:    scaled = widened;
            2'd1:    scaled = widened << 1;
            default: scaled = widened << 2;
        endcase
    end
endmodule

// File: rtl/ea_imm_ext.sv
module ea_imm_ext #(
    parameter int IMM_W = 8,
    parameter int OUT_W = 32
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       cls,
    output logic [OUT_W-1:0] value
);
    import eagen_pkg::*;

    localparam int PAD_W = OUT_W - IMM_W;

    logic [OUT_W-1:0] zext;
    logic [OUT_W-1:0] sext;

    assign zext = {{PAD_W{1'b0}}, imm};
    assign sext = {{PAD_W{imm[IMM_W-1]}}, imm};

    always_comb begin
        unique case (iclass_t'(cls))
            IX_ZERO: value = zext;
            IX_SIGN: value = sext;
            IX_TRAP: value = zext << 2;
            IX_NONE: value = '0;
        endcase
    end
endmodule

// File: rtl/ea_addr_core.sv
module ea_addr_core #(
    parameter int W       = 32,
    parameter int FIELD_W = 8,
    parameter int SHORT_W = 4
) (
    input  logic [2:0]         mode,
    input  logic [1:0]         size,
    input  logic [W-1:0]       rn,
    input  logic [W-1:0]       r0,
    input  logic [W-1:0]       gbr,
    input  logic [W-1:0]       pc,
    input  logic [FIELD_W-1:0] field,
    output logic [W-1:0]       ea,
    output logic               wb_en,
    output logic [W-1:0]       wb_val,
    output logic               misalign
);
    import eagen_pkg::*;

    logic [1:0]   shamt;
    logic [W-1:0] step;
    logic [W-1:0] disp_short;
    logic [W-1:0] disp_long;
    logic [W-1:0] pc_base;
    logic [W-1:0] rn_dec;

    assign shamt  = size_shift(osize_t'(size));
    assign step   = W'(1) << shamt;
    assign rn_dec = rn - step;

    ea_scaler #(.IN_W(SHORT_W), .OUT_W(W)) u_scale_short (
        .disp   (field[SHORT_W-1:0]),
        .shamt  (shamt),
        .scaled (disp_short)
    );

    ea_scaler #(.IN_W(FIELD_W), .OUT_W(W)) u_scale_long (
        .disp   (field),
        .shamt  (shamt),
        .scaled (disp_long)
    );

    assign pc_base = (shamt == 2'd2) ? {pc[W-1:2], 2'b00} : pc;

    always_comb begin
        wb_en  = 1'b0;
        wb_val = '0;
        unique case (amode_t'(mode))
            AM_IND:     ea = rn;
            AM_POSTINC: begin
                ea     = rn;
                wb_en  = 1'b1;
                wb_val = rn + step;
            end
            AM_PREDEC:  begin
                ea     = rn_dec;
                wb_en  = 1'b1;
                wb_val = rn_dec;
            end
            AM_RDISP:   ea = rn + disp_short;
            AM_RIDX:    ea = rn + r0;
            AM_GDISP:   ea = gbr + disp_long;
            AM_GIDX:    ea = gbr + r0;
            AM_PCDISP:  ea = pc_base + disp_long;
        endcase
    end

    always_comb begin
        unique case (shamt)
            2'd0:    misalign = 1'b0;
            2'd1:    misalign = ea[0];
            default: misalign = |ea[1:0];
        endcase
    end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         mode,
    input  logic [1:0]         size,
    input  logic [1:0]         imm_class,
    input  logic [ADDR_W-1:0]  rn,
    input  logic [ADDR_W-1:0]  r0,
    input  logic [ADDR_W-1:0]  gbr,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [FIELD_W-1:0] field,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  ea,
    output logic [ADDR_W-1:0]  imm_value,
    output logic               wb_en,
    output logic [ADDR_W-1:0]  wb_value,
    output logic               misalign
);
    import eagen_pkg::*;

    localparam int SHORT_W = 4;

    ostate_t state_q, state_d;

    logic [ADDR_W-1:0] ea_c, imm_c, wb_c;
    logic              wb_en_c, mis_c;
    logic [2:0]        mode_q;
    logic [1:0]        size_q;
    logic [1:0]        cls_q;

    ea_addr_core #(.W(ADDR_W), .FIELD_W(FIELD_W), .SHORT_W(SHORT_W)) u_core (
        .mode     (mode),
        .size     (size),
        .rn       (rn),
        .r0       (r0),
        .gbr      (gbr),
        .pc       (pc),
        .field    (field),
        .ea       (ea_c),
        .wb_en    (wb_en_c),
        .wb_val   (wb_c),
        .misalign (mis_c)
    );

    ea_imm_ext #(.IMM_W(FIELD_W), .OUT_W(ADDR_W)) u_imm (
        .imm   (field),
        .cls   (imm_class),
        .value (imm_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_RESULT;
            ST_RESULT: if (!req_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        out_valid = (state_q == ST_RESULT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea        <= '0;
            imm_value <= '0;
            wb_en     <= 1'b0;
            wb_value  <= '0;
            misalign  <= 1'b0;
            mode_q    <= '0;
            size_q    <= '0;
            cls_q     <= '0;
        end else if (req_valid) begin
            ea        <= ea_c;
            imm_value <= imm_c;
            wb_en     <= wb_en_c;
            wb_value  <= wb_c;
            misalign  <= mis_c;
            mode_q    <= mode;
            size_q    <= size;
            cls_q     <= imm_class;
        end
    end

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    assert_idle_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(ea) && $stable(wb_value)));
    assert_postinc_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd1) |=> (ea == $past(rn)));
    assert_predec_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q == 3'd2) |-> (wb_value == ea));
    assert_trap_low_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cls_q == 2'd2) |-> (imm_value[1:0] == 2'b00));
    assert_wb_modes_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wb_en) |-> (mode_q == 3'd1 || mode_q == 3'd2));
    assert_byte_never_misaligned_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && size_q == 2'd0) |-> !misalign);
    assert_long_misalign_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && size_q[1] && ea[1:0] != 2'b00) |-> misalign);
endmodule

// File: tb/ea_gen_unit_bench.sv
`timescale 1ns/1ps
module ea_gen_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [1:0]  imm_class = '0;
    logic [31:0] rn = '0, r0 = '0, gbr = '0, pc = '0;
    logic [7:0]  field = '0;
    logic        out_valid, wb_en, misalign;
    logic [31:0] ea, imm_value, wb_value;

    int checks = 0;
    int failures = 0;

    logic [31:0] held_ea = '0, held_imm = '0, held_wb = '0;
    logic        held_wbe = 1'b0, held_mis = 1'b0;

    always #4 clk = ~clk;

    ea_gen_unit u_ea_gen_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .size(size), .imm_class(imm_class), .rn(rn), .r0(r0), .gbr(gbr),
        .pc(pc), .field(field), .out_valid(out_valid), .ea(ea),
        .imm_value(imm_value), .wb_en(wb_en), .wb_value(wb_value),
        .misalign(misalign)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] m, input logic [1:0] s, input logic [1:0] c,
                         input logic [31:0] a_rn, input logic [31:0] a_r0,
                         input logic [31:0] a_gbr, input logic [31:0] a_pc,
                         input logic [7:0] f,
                         output logic [31:0] e_ea, output logic [31:0] e_imm,
                         output logic [31:0] e_wb, output logic e_wbe, output logic e_mis);
        int unsigned stp;
        logic [31:0] base;
        stp = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
        e_wbe = 1'b0;
        e_wb = 32'd0;
        case (m)
            3'd0: e_ea = a_rn;
            3'd1: begin e_ea = a_rn; e_wbe = 1'b1; e_wb = a_rn + stp; end
            3'd2: begin e_ea = a_rn - stp; e_wbe = 1'b1; e_wb = e_ea; end
            3'd3: e_ea = a_rn + 32'(f % 16) * stp;
            3'd4: e_ea = a_rn + a_r0;
            3'd5: e_ea = a_gbr + 32'(f) * stp;
            3'd6: e_ea = a_gbr + a_r0;
            default: begin
                base = (stp == 4) ? (a_pc & 32'hFFFF_FFFC) : a_pc;
                e_ea = base + 32'(f) * stp;
            end
        endcase
        case (c)
            2'd0: e_imm = 32'(f);
            2'd1: e_imm = (f >= 8'd128) ? (32'(f) | 32'hFFFF_FF00) : 32'(f);
            2'd2: e_imm = 32'(f) * 4;
            default: e_imm = 32'd0;
        endcase
        e_mis = (stp == 2 && e_ea[0]) || (stp == 4 && e_ea[1:0] != 2'b00);
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd5: return "R7";
            3'd7: return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic apply(input logic v, input logic [2:0] m, input logic [1:0] s,
                         input logic [1:0] c, input logic [31:0] a_rn,
                         input logic [31:0] a_r0, input logic [31:0] a_gbr,
                         input logic [31:0] a_pc, input logic [7:0] f,
                         input string ea_tag);
        logic [31:0] e_ea, e_imm, e_wb;
        logic e_wbe, e_mis;
        string t;
        @(negedge clk);
        req_valid = v; mode = m; size = s; imm_class = c;
        rn = a_rn; r0 = a_r0; gbr = a_gbr; pc = a_pc; field = f;
        model(m, s, c, a_rn, a_r0, a_gbr, a_pc, f, e_ea, e_imm, e_wb, e_wbe, e_mis);
        @(posedge clk);
        #2;
        if (v) begin
            t = (ea_tag != "") ? ea_tag : mode_tag(m);
            chk("R2", "out_valid", 32'(out_valid), 32'd1);
            chk(t, "ea", ea, e_ea);
            chk((c == 2'd2) ? "R11" : "R10", "imm_value", imm_value, e_imm);
            chk("R12", "wb_en", 32'(wb_en), 32'(e_wbe));
            chk((m == 3'd2) ? "R5" : (m == 3'd1) ? "R4" : "R12", "wb_value", wb_value, e_wb);
            chk("R13", "misalign", 32'(misalign), 32'(e_mis));
            held_ea = e_ea; held_imm = e_imm; held_wb = e_wb;
            held_wbe = e_wbe; held_mis = e_mis;
        end else begin
            chk("R2", "idle out_valid", 32'(out_valid), 32'd0);
            chk("R2", "idle ea hold", ea, held_ea);
            chk("R2", "idle imm hold", imm_value, held_imm);
            chk("R2", "idle wb hold", wb_value, held_wb);
            chk("R2", "idle flags hold", {30'd0, wb_en, misalign}, {30'd0, held_wbe, held_mis});
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] s_ea, s_imm, s_wb;
        logic s_wbe, s_mis;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R1", "reset ea", ea, 32'd0);
        chk("R1", "reset imm", imm_value, 32'd0);
        chk("R1", "reset wb", wb_value, 32'd0);
        chk("R1", "reset flags", {30'd0, wb_en, misalign}, 32'd0);

        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 4; s++) begin
                apply(1'b1, 3'(m), 2'(s), 2'(s), 32'h1000_0013, 32'h0000_0105,
                      32'h2000_0002, 32'h0000_4006, 8'hB7, "");
            end
        end

        apply(1'b1, 3'd1, 2'd2, 2'd0, 32'hFFFF_FFFE, 0, 0, 0, 8'h00, "R9");
        apply(1'b1, 3'd2, 2'd1, 2'd0, 32'h0000_0000, 0, 0, 0, 8'h00, "R9");
        apply(1'b1, 3'd4, 2'd0, 2'd0, 32'hFFFF_FFF0, 32'h0000_0020, 0, 0, 8'h00, "R9");
        apply(1'b1, 3'd5, 2'd2, 2'd0, 0, 0, 32'hFFFF_FF00, 0, 8'hFF, "R9");
        apply(1'b1, 3'd7, 2'd2, 2'd0, 0, 0, 0, 32'h0000_1006, 8'h01, "R8");
        chk("R8", "pc long masked", ea, 32'h0000_1008);
        apply(1'b1, 3'd7, 2'd1, 2'd0, 0, 0, 0, 32'h0000_1006, 8'h01, "R8");
        chk("R8", "pc word unmasked", ea, 32'h0000_1008);
        apply(1'b1, 3'd3, 2'd1, 2'd1, 32'h0000_0100, 0, 0, 0, 8'hF3, "R6");
        chk("R6", "upper field bits ignored", ea, 32'h0000_0106);
        chk("R10", "sign extend 0xF3", imm_value, 32'hFFFF_FFF3);
        apply(1'b1, 3'd0, 2'd0, 2'd1, 0, 0, 0, 0, 8'h7F, "");
        chk("R10", "sign extend 0x7F", imm_value, 32'h0000_007F);
        apply(1'b1, 3'd0, 2'd0, 2'd2, 0, 0, 0, 0, 8'hFF, "");
        chk("R11", "trap 0xFF", imm_value, 32'h0000_03FC);
        apply(1'b1, 3'd0, 2'd0, 2'd3, 0, 0, 0, 0, 8'hFF, "");
        chk("R10", "class none", imm_value, 32'd0);
        apply(1'b1, 3'd2, 2'd3, 2'd0, 32'h0000_0100, 0, 0, 0, 8'h00, "R14");
        chk("R14", "size3 predec", ea, 32'h0000_00FC);
        apply(1'b1, 3'd0, 2'd1, 2'd0, 32'h0000_0003, 0, 0, 0, 8'h00, "");
        chk("R13", "word odd", 32'(misalign), 32'd1);
        apply(1'b1, 3'd0, 2'd0, 2'd0, 32'h0000_0003, 0, 0, 0, 8'h00, "");
        chk("R13", "byte odd", 32'(misalign), 32'd0);
        apply(1'b0, 3'd1, 2'd2, 2'd2, 32'h5555_5555, 1, 1, 1, 8'h11, "");
        apply(1'b0, 3'd7, 2'd0, 2'd1, 32'hAAAA_AAAA, 2, 2, 2, 8'h22, "");

        for (int i = 0; i < 600; i++) begin
            logic v;
            v = ($urandom % 5) != 0;
            apply(v, 3'($urandom), 2'($urandom), 2'($urandom), $urandom, $urandom,
                  $urandom, $urandom, 8'($urandom), "");
        end

        model(3'd1, 2'd1, 2'd0, 32'h10, 0, 0, 0, 0, s_ea, s_imm, s_wb, s_wbe, s_mis);
        chk("R4", "model sanity step word", s_wb, 32'h12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule